// File: doc/BRIEF.md
# Conversion Result Handshake Gate

This block sits between a converter core that produces a new measurement without pause and the latch that feeds a numeric display. The core raises a one-cycle end-of-conversion strobe together with its newest result. The gate decides which of those strobes actually reaches the display register. It never slows, stops or restarts the core. It only chooses the moment the display register is loaded.

A request comes from an asynchronous start input. The input is resynchronised, and its rising edge is kept in a set/reset request latch, so a pulse of any width counts as exactly one request. The request waits through a settling window and is then served by the next end-of-conversion strobe. At that strobe the result is copied to the display and the completion flag rises. The completion flag drops when a new start edge is registered. If start is held high, the gate runs free: the completion flag stays up for a fixed number of cycles after each transfer, then drops and files a fresh request, so the display follows every conversion frame.

Top module: `conv_result_gate`

## Requirements
- R1: After reset the completion flag `done_o` is 0, the display word `disp_o` is all zeros and no request is pending.
- R2: `start_i` passes through SYNC_STAGES flip-flops before edge detection. With the default of 2, a rise of `start_i` set up before clock edge k is registered at edge k+2, and any response appears right after that edge.
- R3: When a start rising edge is registered and no transfer happens on the same edge, `done_o` goes to 0 on that edge.
- R4: When `eoc_i` is sampled high on an edge while a ready request is pending, `disp_o` takes the `result_i` value present on that edge, `done_o` becomes 1 on that edge, and the request is cleared.
- R5: A request becomes ready SETTLE_CYCLES edges after the edge that registered it. An `eoc_i` strobe on an earlier edge is skipped: `disp_o` is unchanged and `done_o` stays 0.
- R6: A start pulse of any width from one clock cycle upward creates exactly one request. A level held high counts as a single rising edge.
- R7: An `eoc_i` strobe while no request is pending leaves `disp_o` and `done_o` unchanged.
- R8: A start rising edge registered while a request is already pending merges into that request. It does not restart the settling window, and only one transfer results. A start edge on the same clock edge as a transfer is absorbed by that transfer.
- R9: While the synchronised start level is high, `done_o` stays 1 for exactly DONE_HOLD cycles after each transfer. It then falls and a new request is registered on that same edge.
- R10: While the synchronised start level is low, `done_o` stays 1 after a transfer until the next registered start rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the converter core |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous start request; tie high for free-running updates |
| eoc_i | input | 1 | One-cycle end-of-conversion strobe from the core |
| result_i | input | DATA_W | Result word from the core, valid with `eoc_i` |
| disp_o | output | DATA_W | Display register contents |
| done_o | output | 1 | Conversion-complete flag |

## Verification
Each `eoc_i` strobe that reaches the display shows its result and a high `done_o` right after the same edge that sampled the strobe, so the bench checks at the following falling edge. A start rise shows up as a falling `done_o` three edges after the input changes, and the bench samples just before and just after that third edge. Skipped strobes are placed well inside the settling window. The free-running hold is counted over the falling edges of each frame. A cycle model built from the requirements, clocked on the same edges, is compared against both outputs at every falling edge, including during a long random stretch of pulses and strobes.

// File: rtl/cvg_pkg.sv
package cvg_pkg;

    // Request latch phases
    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_SETTLE = 2'd1,
        REQ_ARMED  = 2'd2
    } req_state_e;

endpackage

// File: rtl/cvg_start_sync.sv
module cvg_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], start_i};
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.chain[STAGES-1];
    assign rise_o  = q.chain[STAGES-1] & ~q.prev;

endmodule

// File: rtl/cvg_req_ctrl.sv
module cvg_req_ctrl
    import cvg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 512,
    parameter int DONE_HOLD     = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_i,
    input  logic eoc_i,
    output logic xfer_o,
    output logic done_o,
    output logic pending_o
);

    localparam int AW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam int HW = (DONE_HOLD > 1) ? $clog2(DONE_HOLD) : 1;
    localparam logic [AW-1:0] ARM_LOAD = AW'(SETTLE_CYCLES - 1);
    localparam logic [HW-1:0] HOLD_END = HW'(DONE_HOLD - 1);

    typedef struct packed {
        req_state_e    st;
        logic [AW-1:0] arm_cnt;
        logic [HW-1:0] hold_cnt;
        logic          done;
    } ctrl_t;

    ctrl_t q, d;
    logic  ready, rearm, holding, xfer;

    always_comb begin
        d       = q;
        xfer    = 1'b0;
        ready   = (q.st == REQ_ARMED) ||
                  ((q.st == REQ_SETTLE) && (q.arm_cnt == '0));
        holding = q.done && level_i && (q.st == REQ_IDLE);
        rearm   = holding && (q.hold_cnt == HOLD_END);

        // free-running hold timer
        if (holding) d.hold_cnt = q.hold_cnt + 1'b1;

        // settling window advances on its own
        if (q.st == REQ_SETTLE) begin
            if (q.arm_cnt == '0) d.st = REQ_ARMED;
            else                 d.arm_cnt = q.arm_cnt - 1'b1;
        end

        if (eoc_i && ready) begin
            xfer       = 1'b1;
            d.st       = REQ_IDLE;
            d.done     = 1'b1;
            d.hold_cnt = '0;
        end else if (rise_i || rearm) begin
            d.done     = 1'b0;
            d.hold_cnt = '0;
            if (q.st == REQ_IDLE) begin
                d.st      = REQ_SETTLE;
                d.arm_cnt = ARM_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= REQ_IDLE;
            q.arm_cnt  <= '0;
            q.hold_cnt <= '0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign xfer_o    = xfer;
    assign done_o    = q.done;
    assign pending_o = (q.st != REQ_IDLE);

endmodule

// File: rtl/cvg_result_reg.sv
module cvg_result_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] val_q, val_d;

    always_comb begin
        val_d = val_q;
        if (load_i) val_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign data_o = val_q;

endmodule

// File: rtl/conv_result_gate.sv
module conv_result_gate #(
    parameter int DATA_W        = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 512,
    parameter int DONE_HOLD     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              eoc_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] disp_o,
    output logic              done_o
);

    logic lvl_w, rise_w, xfer_w, pend_w;

    cvg_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .level_o (lvl_w),
        .rise_o  (rise_w)
    );

    cvg_req_ctrl #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .DONE_HOLD     (DONE_HOLD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (lvl_w),
        .rise_i    (rise_w),
        .eoc_i     (eoc_i),
        .xfer_o    (xfer_w),
        .done_o    (done_o),
        .pending_o (pend_w)
    );

    cvg_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (xfer_w),
        .data_i (result_i),
        .data_o (disp_o)
    );

endmodule

// File: rtl/cvg_checker.sv
module cvg_checker #(
    parameter int DATA_W        = 16,
    parameter int SETTLE_CYCLES = 512,
    parameter int DONE_HOLD     = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [DATA_W-1:0] disp_o,
    input logic [DATA_W-1:0] result_i,
    input logic              start_lvl,
    input logic              start_rise,
    input logic              xfer,
    input logic              pending
);

    localparam int AGW = $clog2(SETTLE_CYCLES + 1);
    localparam int RNW = $clog2(DONE_HOLD + 2);

    logic [AGW-1:0] age_q;
    logic [RNW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         age_q <= '0;
        else if (!pending)                  age_q <= '0;
        else if (age_q < AGW'(SETTLE_CYCLES)) age_q <= age_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                run_q <= '0;
        else if (done_o && start_lvl && !pending) begin
            if (run_q < RNW'(DONE_HOLD + 1))       run_q <= run_q + 1'b1;
        end else                                   run_q <= '0;
    end

    // R4
    xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (done_o && (disp_o == $past(result_i))));

    // R7
    disp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(disp_o));

    // R3
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rise && !xfer) |=> !done_o);

    // R5
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (age_q >= AGW'(SETTLE_CYCLES - 1)));

    // R9
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RNW'(DONE_HOLD));

    // R8
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && start_rise && !xfer) |=> pending);

endmodule

bind conv_result_gate cvg_checker #(
    .DATA_W        (DATA_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .DONE_HOLD     (DONE_HOLD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .disp_o     (disp_o),
    .result_i   (result_i),
    .start_lvl  (lvl_w),
    .start_rise (rise_w),
    .xfer       (xfer_w),
    .pending    (pend_w)
);

// File: tb/sim_conv_result_gate.sv
module sim_conv_result_gate;

    localparam int W    = 16;
    localparam int GAP  = 512;
    localparam int HOLD = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         eoc = 1'b0;
    logic [W-1:0] result = '0;
    logic [W-1:0] disp_o;
    logic         done_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    conv_result_gate u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .eoc_i    (eoc),
        .result_i (result),
        .disp_o   (disp_o),
        .done_o   (done_o)
    );

    // reference model built from the requirements
    logic         m_s1, m_s2, m_prev, m_pend, m_done;
    logic [W-1:0] m_disp;
    int           m_req_edge, m_hrun, cyc;
    logic         mr, mrdy, mrearm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_pend <= 0; m_done <= 0;
            m_disp <= '0; m_req_edge <= 0; m_hrun <= 0; cyc <= 0;
        end else begin
            mr     = m_s2 && !m_prev;
            mrdy   = m_pend && ((cyc - m_req_edge) >= GAP);
            mrearm = m_done && m_s2 && !m_pend && (m_hrun == HOLD - 1);
            cyc  <= cyc + 1;
            m_s1 <= start; m_s2 <= m_s1; m_prev <= m_s2;
            if (m_done && m_s2 && !m_pend) m_hrun <= m_hrun + 1;
            if (eoc && mrdy) begin
                m_disp <= result; m_done <= 1; m_pend <= 0; m_hrun <= 0;
            end else if (mr || mrearm) begin
                m_done <= 0; m_hrun <= 0;
                if (!m_pend) begin m_pend <= 1; m_req_edge <= cyc; end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk({cur_tag, " disp"}, int'(disp_o), int'(m_disp));
            chk({cur_tag, " done"}, int'(done_o), int'(m_done));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eoc(input logic [W-1:0] v);
        eoc = 1'b1; result = v;
        step(1);
        eoc = 1'b0;
    endtask

    function automatic int hold_expect();
        return HOLD;
    endfunction

    initial begin
        int unsigned seed;
        int hi;
        int plen;
        int ecnt;
        logic [W-1:0] fr;
        seed = $urandom(32'd4242);
        step(4);
        // R1 reset state
        chk("R1 done", int'(done_o), 0);
        chk("R1 disp", int'(disp_o), 0);
        rst_n = 1'b1;
        step(2);
        cmp_en = 1'b1;

        // R6 single-cycle pulse, then R4 transfer
        cur_tag = "R6";
        start = 1'b1; step(1); start = 1'b0;
        step(GAP + 20);
        cur_tag = "R4";
        pulse_eoc(16'h1234);
        chk("R4 disp", int'(disp_o), 16'h1234);
        chk("R4 done", int'(done_o), 1);

        // R2/R3 latency of done fall
        cur_tag = "R3";
        start = 1'b1;
        step(2);
        chk("R2 done before third edge", int'(done_o), 1);
        step(1);
        chk("R3 done after third edge", int'(done_o), 0);
        step(40); start = 1'b0;

        // R5 early strobe skipped
        cur_tag = "R5";
        step(60);
        pulse_eoc(16'h5555);
        chk("R5 disp", int'(disp_o), 16'h1234);
        chk("R5 done", int'(done_o), 0);
        step(500);
        pulse_eoc(16'h0A0A);
        chk("R5 late disp", int'(disp_o), 16'h0A0A);

        // R7 strobe without request
        cur_tag = "R7";
        step(10);
        pulse_eoc(16'h7777);
        chk("R7 disp", int'(disp_o), 16'h0A0A);
        chk("R7 done", int'(done_o), 1);

        // R10 done stays high with start low
        cur_tag = "R10";
        step(300);
        chk("R10 done", int'(done_o), 1);

        // R8 merge without window restart
        cur_tag = "R8";
        start = 1'b1; step(3); start = 1'b0;
        step(200);
        start = 1'b1; step(3); start = 1'b0;
        step(330);
        pulse_eoc(16'h0808);
        chk("R8 merged transfer", int'(disp_o), 16'h0808);
        step(300);
        pulse_eoc(16'h0909);
        chk("R8 single transfer", int'(disp_o), 16'h0808);

        // R9 free running
        cur_tag = "R9";
        start = 1'b1;
        step(999);
        for (int f = 0; f < 6; f++) begin
            fr = W'($urandom());
            pulse_eoc(fr);
            chk("R9 frame update", int'(disp_o), int'(fr));
            hi = done_o ? 1 : 0;
            for (int k = 0; k < 998; k++) begin
                step(1);
                if (done_o) hi++;
            end
            chk("R9 hold length", hi, hold_expect());
        end
        start = 1'b0;
        step(10);

        // random mix, compared against the model (R8 merges, R5 skips)
        cur_tag = "R8 random";
        plen = 0;
        ecnt = 300;
        for (int c = 0; c < 60000; c++) begin
            if (plen > 0) begin
                plen--; start = 1'b1;
            end else begin
                start = 1'b0;
                if (($urandom() % 500) == 0) plen = 1 + ($urandom() % 60);
            end
            if (ecnt == 0) begin
                eoc = 1'b1; result = W'($urandom());
                ecnt = 400 + ($urandom() % 900);
            end else begin
                eoc = 1'b0; ecnt--;
            end
            step(1);
        end
        eoc = 1'b0; start = 1'b0;
        step(5);
        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(1_900_000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule